// File: doc/BRIEF.md
# Memory Protection Region Checker

This block sits beside a processor's load/store and fetch path and judges every bus access against a table of eight programmable protection regions. Each access comes with an address, a write flag, an instruction-fetch flag and a privilege flag. One clock cycle later the block reports whether the access is allowed or faults, and it gives a fault cause. Data faults record the offending address, and any fault sets sticky status flags that software can read and then clear.

Privileged software programs the table through a small register port. It selects a region, then writes that region's base, its power-of-two size, a mask that disables any of its eight equal subregions, a 3-bit permission code and an execute-never bit. It also enables the whole unit and a privileged-only background region. When regions overlap, the highest-numbered region that matches decides. Fetches and data accesses are checked against the same table.

Top module: `prot_region_unit`

## Requirements
- R1: The unit holds eight regions, numbered 0 to 7. An enabled region matches when the address bits at and above bit N+1 equal its base, where N is the 5-bit size field and the region spans 2^(N+1) bytes. Size values below 4 act as 4, giving 32 bytes. Base bits below the region size are ignored.
- R2: When several enabled regions match, only the highest-numbered one supplies the permission code and the execute-never bit.
- R3: A region of 256 bytes or more is divided into eight equal subregions. Subregion k is address bits [N-2 +: 3] = k. If bit k of the region's disable mask is set, that subregion does not match, and the lookup falls to lower regions or to the background. Smaller regions ignore the mask.
- R4: Permission code decoding, given as privileged/unprivileged access: 000 none/none. 001 read-write/none. 010 read-write/read-only. 011 read-write/read-write. 100 none/none. 101 read-only/none. 110 and 111 read-only/read-only. A disallowed access faults with cause 1.
- R5: An instruction fetch that hits a region with execute-never set faults with cause 2, whatever its permission code. A fetch is otherwise checked as a read.
- R6: An address that matches no region is allowed for privileged accesses when the background enable is set. An unprivileged access to such an address faults with cause 3. With the background disabled, every access to such an address faults with cause 3.
- R7: While the unit enable is clear, every access is allowed, no fault is reported and the status does not change.
- R8: For each cycle with acc_valid high, res_valid is high in the next cycle, together with res_fault and res_cause. Cause codes: 0 none, 1 permission, 2 execute-never, 3 no region. res_fault is low whenever res_valid is low.
- R9: Register writes take effect only when cfg_priv is high. The registers are selected by cfg_sel, and a read returns its data on cfg_rdata one cycle later. Selector 0 is control: bit 0 enables the unit, bit 1 enables the background. Selector 1 is the region number, in bits 2:0. Selector 2 is the base, in bits 31:5. Selector 3 holds the attributes: bit 0 enables the region, bits 5:1 are the size, bits 15:8 the subregion disable mask, bits 26:24 the permission code and bit 28 execute-never. Selector 4 is status. Selector 5 is the fault address.
- R10: A write to the base register with bit 4 set first loads the region number from bits 2:0 of that write and then targets that region. With bit 4 clear, the write targets the current region number. Reading the base register returns the current region number in bits 2:0.
- R11: A fault on a fetch sets status bit 0. A fault on a data access sets status bit 1, and if status bit 7 is clear it captures the address and sets bit 7. While bit 7 stays set, later faults leave the captured address unchanged.
- R12: Status bits 0, 1 and 7 are cleared by writing 1 to them, so writing back the value read clears them. Writing 0 to a bit leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Access address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_priv | input | 1 | Access is privileged |
| res_valid | output | 1 | Verdict for the previous cycle's access |
| res_fault | output | 1 | Access faulted |
| res_cause | output | 2 | Fault cause code |
| cfg_valid | input | 1 | Register port request |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_priv | input | 1 | Register request is privileged |
| cfg_sel | input | 3 | Register selector |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, one cycle after a read |

## Verification
The bench overlaps a large region with a higher-numbered small one that has tighter permissions. A priority encoder that favoured the low number would let the unprivileged write through. It disables one subregion so that only that slice falls to the background and reports cause 3 instead of cause 1. It also gives a 128-byte region a full disable mask, which a design that applied the mask to small regions would wrongly reject. It sweeps all eight permission codes against the four privilege and direction combinations, including the reserved code. It programs a base with stray low bits and a size field below the minimum, which a design that did not mask the base or clamp the size would mis-match. Finally it checks that a second data fault leaves the first captured address in place, that an unprivileged register write is ignored, and that a disabled unit raises no fault and leaves the status unchanged.

// File: rtl/prot_pkg.sv
package prot_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_PERM = 2'd1,
    CAUSE_XN   = 2'd2,
    CAUSE_BG   = 2'd3
  } cause_e;

  typedef struct packed {
    logic       en;
    logic [4:0] size;
    logic [7:0] srd;
    logic [2:0] perm;
    logic       xn;
  } attr_t;

  localparam logic [2:0] SEL_CTRL  = 3'd0;
  localparam logic [2:0] SEL_RNUM  = 3'd1;
  localparam logic [2:0] SEL_BASE  = 3'd2;
  localparam logic [2:0] SEL_ATTR  = 3'd3;
  localparam logic [2:0] SEL_STAT  = 3'd4;
  localparam logic [2:0] SEL_FADDR = 3'd5;

  localparam int MIN_SIZE   = 4;
  localparam int SUB_MIN_SZ = 7;

  function automatic logic perm_allows(input logic [2:0] code,
                                       input logic priv,
                                       input logic wr);
    logic ok;
    case (code)
      3'b001:  ok = priv;
      3'b010:  ok = priv | ~wr;
      3'b011:  ok = 1'b1;
      3'b101:  ok = priv & ~wr;
      3'b110,
      3'b111:  ok = ~wr;
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/prot_region_match.sv
module prot_region_match
  import prot_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  attr_t             attr,
  output logic              hit
);

  logic [4:0]        n_eff;
  logic [5:0]        top;
  logic [ADDR_W-1:0] shifted;
  logic [2:0]        sub_idx;

  always_comb begin
    n_eff   = (attr.size < 5'(MIN_SIZE)) ? 5'(MIN_SIZE) : attr.size;
    top     = {1'b0, n_eff} + 6'd1;
    shifted = addr >> (n_eff - 5'd2);
    sub_idx = shifted[2:0];
    hit     = attr.en;
    for (int i = 0; i < ADDR_W; i++) begin
      if (i >= int'(top) && addr[i] != base[i]) hit = 1'b0;
    end
    if (n_eff >= 5'(SUB_MIN_SZ) && attr.srd[sub_idx]) hit = 1'b0;
  end

endmodule

// File: rtl/prot_cfg_regs.sv
module prot_cfg_regs
  import prot_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NREG   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_valid,
  input  logic              cfg_write,
  input  logic              cfg_priv,
  input  logic [2:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              flt_evt,
  input  logic              flt_fetch,
  input  logic [ADDR_W-1:0] flt_addr,
  output logic              unit_en,
  output logic              bg_en,
  output logic [ADDR_W-1:0] base_q [NREG],
  output attr_t             attr_q [NREG]
);

  localparam int RW = $clog2(NREG);

  logic [RW-1:0]     rnum;
  logic              st_inst, st_data, st_av;
  logic [ADDR_W-1:0] fault_addr;
  logic              wr_ok;
  logic [RW-1:0]     base_tgt;
  logic              clr_av;
  logic              unused_wbits;

  assign wr_ok    = cfg_valid & cfg_write & cfg_priv;
  assign base_tgt = cfg_wdata[4] ? cfg_wdata[RW-1:0] : rnum;
  assign clr_av   = wr_ok && cfg_sel == SEL_STAT && cfg_wdata[7];
  assign unused_wbits = ^{cfg_wdata[31:29], cfg_wdata[27], cfg_wdata[23:16],
                          cfg_wdata[6:2]};

  // control, region number and region table
  always_ff @(posedge clk) begin
    if (rst) begin
      unit_en <= 1'b0;
      bg_en   <= 1'b0;
      rnum    <= '0;
      for (int r = 0; r < NREG; r++) begin
        base_q[r] <= '0;
        attr_q[r] <= '0;
      end
    end else if (wr_ok) begin
      case (cfg_sel)
        SEL_CTRL: begin
          unit_en <= cfg_wdata[0];
          bg_en   <= cfg_wdata[1];
        end
        SEL_RNUM: rnum <= cfg_wdata[RW-1:0];
        SEL_BASE: begin
          if (cfg_wdata[4]) rnum <= cfg_wdata[RW-1:0];
          base_q[base_tgt] <= {cfg_wdata[ADDR_W-1:5], 5'b0};
        end
        SEL_ATTR: attr_q[rnum] <= '{en:   cfg_wdata[0],
                                    size: cfg_wdata[5:1],
                                    srd:  cfg_wdata[15:8],
                                    perm: cfg_wdata[26:24],
                                    xn:   cfg_wdata[28]};
        default: ;
      endcase
    end
  end

  // fault status and captured address
  always_ff @(posedge clk) begin
    if (rst) begin
      st_inst    <= 1'b0;
      st_data    <= 1'b0;
      st_av      <= 1'b0;
      fault_addr <= '0;
    end else begin
      if (wr_ok && cfg_sel == SEL_STAT) begin
        if (cfg_wdata[0]) st_inst <= 1'b0;
        if (cfg_wdata[1]) st_data <= 1'b0;
        if (cfg_wdata[7]) st_av   <= 1'b0;
      end
      if (flt_evt) begin
        if (flt_fetch) begin
          st_inst <= 1'b1;
        end else begin
          st_data <= 1'b1;
          if (!st_av || clr_av) begin
            st_av      <= 1'b1;
            fault_addr <= flt_addr;
          end
        end
      end
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else if (cfg_valid && !cfg_write) begin
      case (cfg_sel)
        SEL_CTRL:  cfg_rdata <= {30'b0, bg_en, unit_en};
        SEL_RNUM:  cfg_rdata <= 32'(rnum);
        SEL_BASE:  cfg_rdata <= 32'(base_q[rnum]) | 32'(rnum);
        SEL_ATTR:  cfg_rdata <= {3'b0, attr_q[rnum].xn, 1'b0, attr_q[rnum].perm,
                                 8'b0, attr_q[rnum].srd, 2'b0,
                                 attr_q[rnum].size, attr_q[rnum].en};
        SEL_STAT:  cfg_rdata <= {24'b0, st_av, 5'b0, st_data, st_inst};
        SEL_FADDR: cfg_rdata <= 32'(fault_addr);
        default:   cfg_rdata <= '0;
      endcase
    end
  end

  AST_UNPRIV_CFG_IGNORED: assert property (@(posedge clk) disable iff (rst) // R9
    (cfg_valid && cfg_write && !cfg_priv) |=> ($stable(unit_en) && $stable(bg_en) && $stable(rnum)));

  AST_FADDR_HELD: assert property (@(posedge clk) disable iff (rst) // R11
    (st_av && !clr_av) |=> $stable(fault_addr));

  AST_W1C_DATA: assert property (@(posedge clk) disable iff (rst) // R12
    (wr_ok && cfg_sel == SEL_STAT && cfg_wdata[1] && !flt_evt) |=> !st_data);

endmodule

// File: rtl/prot_decide.sv
module prot_decide
  import prot_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NREG   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic              acc_fetch,
  input  logic              acc_priv,
  input  logic [NREG-1:0]   hit,
  input  attr_t             attr_q [NREG],
  input  logic              unit_en,
  input  logic              bg_en,
  output logic              res_valid,
  output logic              res_fault,
  output logic [1:0]        res_cause,
  output logic              flt_evt,
  output logic              flt_fetch,
  output logic [ADDR_W-1:0] flt_addr
);

  localparam int RW = $clog2(NREG);

  logic          found;
  logic [RW-1:0] win_idx;
  attr_t         win;
  logic          eff_wr;
  cause_e        cause_c;
  logic          unused_fields;

  // ascending scan: the last (highest-numbered) hit wins
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit[i]) begin
        found   = 1'b1;
        win_idx = RW'(i);
      end
    end
  end

  assign win    = attr_q[win_idx];
  assign eff_wr = acc_write & ~acc_fetch;
  assign unused_fields = ^{win.en, win.size, win.srd};

  always_comb begin
    cause_c = CAUSE_NONE;
    if (unit_en) begin
      if (found) begin
        if (acc_fetch && win.xn)                        cause_c = CAUSE_XN;
        else if (!perm_allows(win.perm, acc_priv, eff_wr)) cause_c = CAUSE_PERM;
      end else if (!(bg_en && acc_priv)) begin
        cause_c = CAUSE_BG;
      end
    end
  end

  assign flt_evt   = acc_valid && cause_c != CAUSE_NONE;
  assign flt_fetch = acc_fetch;
  assign flt_addr  = acc_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_fault <= 1'b0;
      res_cause <= CAUSE_NONE;
    end else begin
      res_valid <= acc_valid;
      res_fault <= flt_evt;
      res_cause <= acc_valid ? cause_c : CAUSE_NONE;
    end
  end

  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (rst) // R8
    acc_valid |=> res_valid);

  AST_IDLE_NO_FAULT: assert property (@(posedge clk) disable iff (rst) // R8
    !res_valid |-> !res_fault);

  AST_OFF_ALLOWS: assert property (@(posedge clk) disable iff (rst) // R7
    (acc_valid && !unit_en) |=> !res_fault);

  AST_XN_FETCH: assert property (@(posedge clk) disable iff (rst) // R5
    (acc_valid && unit_en && found && acc_fetch && attr_q[win_idx].xn) |=> (res_fault && res_cause == CAUSE_XN));

  AST_BG_UNPRIV: assert property (@(posedge clk) disable iff (rst) // R6
    (acc_valid && unit_en && hit == '0 && !acc_priv) |=> res_fault);

endmodule

// File: rtl/prot_region_unit.sv
module prot_region_unit
  import prot_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NREG   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic              acc_fetch,
  input  logic              acc_priv,
  output logic              res_valid,
  output logic              res_fault,
  output logic [1:0]        res_cause,
  input  logic              cfg_valid,
  input  logic              cfg_write,
  input  logic              cfg_priv,
  input  logic [2:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata
);

  logic [ADDR_W-1:0] base_q [NREG];
  attr_t             attr_q [NREG];
  logic [NREG-1:0]   hit;
  logic              unit_en, bg_en;
  logic              flt_evt, flt_fetch;
  logic [ADDR_W-1:0] flt_addr;

  prot_cfg_regs #(.ADDR_W(ADDR_W), .NREG(NREG)) u_cfg (
    .clk(clk), .rst(rst),
    .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_priv(cfg_priv),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .flt_evt(flt_evt), .flt_fetch(flt_fetch), .flt_addr(flt_addr),
    .unit_en(unit_en), .bg_en(bg_en), .base_q(base_q), .attr_q(attr_q)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_match
    prot_region_match #(.ADDR_W(ADDR_W)) u_match (
      .addr(acc_addr), .base(base_q[g]), .attr(attr_q[g]), .hit(hit[g])
    );
  end

  prot_decide #(.ADDR_W(ADDR_W), .NREG(NREG)) u_decide (
    .clk(clk), .rst(rst),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write),
    .acc_fetch(acc_fetch), .acc_priv(acc_priv),
    .hit(hit), .attr_q(attr_q), .unit_en(unit_en), .bg_en(bg_en),
    .res_valid(res_valid), .res_fault(res_fault), .res_cause(res_cause),
    .flt_evt(flt_evt), .flt_fetch(flt_fetch), .flt_addr(flt_addr)
  );

endmodule

// File: tb/prot_region_unit_test.sv
`timescale 1ns/1ps
module prot_region_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 0, acc_write = 0, acc_fetch = 0, acc_priv = 0;
  logic [31:0] acc_addr = '0;
  logic        res_valid, res_fault;
  logic [1:0]  res_cause;
  logic        cfg_valid = 0, cfg_write = 0, cfg_priv = 0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [2:0] exp_q [$];
  string      tag_q [$];

  always #5 clk = ~clk;

  prot_region_unit uut (
    .clk(clk), .rst(rst),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write),
    .acc_fetch(acc_fetch), .acc_priv(acc_priv),
    .res_valid(res_valid), .res_fault(res_fault), .res_cause(res_cause),
    .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_priv(cfg_priv),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // monitor: pop expected verdicts as results appear
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (exp_q.size() == 0) begin
        chk("R8 unexpected result", {29'b0, res_fault, res_cause}, 32'hFFFF_FFFF);
      end else begin
        chk(tag_q.pop_front(), {29'b0, res_fault, res_cause}, {29'b0, exp_q.pop_front()});
      end
    end
  end

  task automatic acc(input logic [31:0] a, input bit wr, input bit fe, input bit pr,
                     input logic [1:0] cause, input string tag);
    @(negedge clk);
    exp_q.push_back({cause != 2'd0, cause});
    tag_q.push_back(tag);
    acc_valid = 1; acc_addr = a; acc_write = wr; acc_fetch = fe; acc_priv = pr;
    @(negedge clk);
    acc_valid = 0;
  endtask

  task automatic cfg_wr(input logic [2:0] sel, input logic [31:0] d, input bit pr);
    @(negedge clk);
    cfg_valid = 1; cfg_write = 1; cfg_priv = pr; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_valid = 0; cfg_write = 0;
  endtask

  task automatic cfg_chk(input logic [2:0] sel, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_valid = 1; cfg_write = 0; cfg_priv = 1; cfg_sel = sel;
    @(negedge clk);
    cfg_valid = 0;
    chk(tag, cfg_rdata, exp);
  endtask

  function automatic logic [31:0] attr_word(input bit en, input logic [4:0] sz,
      input logic [7:0] srd, input logic [2:0] perm, input bit xn);
    return 32'(en) | (32'(sz) << 1) | (32'(srd) << 8) | (32'(perm) << 24) | (32'(xn) << 28);
  endfunction

  task automatic prog(input int r, input logic [31:0] base, input logic [4:0] sz,
                      input logic [7:0] srd, input logic [2:0] perm, input bit xn);
    cfg_wr(3'd2, base | 32'h10 | 32'(r), 1);
    cfg_wr(3'd3, attr_word(1, sz, srd, perm, xn), 1);
  endtask

  function automatic bit perm_ok(input int code, input bit pr, input bit wr);
    case (code)
      1: return pr;
      2: return pr | !wr;
      3: return 1;
      5: return pr & !wr;
      6, 7: return !wr;
      default: return 0;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R8 reset res_valid", {31'b0, res_valid}, 0);
    chk("R8 reset res_fault", {31'b0, res_fault}, 0);
    cfg_chk(3'd0, 0, "R9 reset control");
    cfg_chk(3'd4, 0, "R11 reset status");

    // unit disabled: everything passes
    acc(32'h7000_0000, 1, 0, 0, 2'd0, "R7 disabled unpriv write");

    // region table
    prog(0, 32'h4000_0000, 5'd12, 8'h00, 3'b011, 0);
    cfg_wr(3'd1, 32'd1, 1);
    cfg_wr(3'd2, 32'h4000_1000, 1);                       // R10 valid bit clear
    cfg_wr(3'd3, attr_word(1, 5'd9, 8'h00, 3'b010, 0), 1);
    cfg_chk(3'd2, 32'h4000_1001, "R10 base readback without valid bit");
    prog(2, 32'h2000_0000, 5'd12, 8'h04, 3'b001, 0);
    prog(3, 32'h3000_0000, 5'd6, 8'hFF, 3'b011, 0);
    prog(4, 32'h5000_1220, 5'd15, 8'h00, 3'b110, 0);
    cfg_chk(3'd1, 32'd4, "R10 region number loaded by base write");
    prog(5, 32'h6000_0000, 5'd0, 8'h00, 3'b011, 0);
    cfg_wr(3'd0, 32'd3, 1);

    acc(32'h4000_0100, 1, 0, 0, 2'd0, "R1 region 0 full access");
    acc(32'h4000_1100, 1, 0, 0, 2'd1, "R2 higher region wins on overlap");
    acc(32'h4000_1100, 0, 0, 0, 2'd0, "R2 higher region read allowed");
    acc(32'h4000_1400, 1, 0, 0, 2'd0, "R1 past small region back to region 0");
    acc(32'h2000_0100, 0, 0, 0, 2'd1, "R3 enabled subregion priv-only");
    acc(32'h2000_0900, 0, 0, 0, 2'd3, "R3 disabled subregion falls to background");
    acc(32'h2000_0900, 0, 0, 1, 2'd0, "R6 privileged background allowed");
    acc(32'h3000_0070, 0, 0, 0, 2'd0, "R3 small region ignores disable mask");
    acc(32'h5000_0010, 0, 0, 0, 2'd0, "R1 base low bits ignored");
    acc(32'h5000_0010, 1, 0, 0, 2'd1, "R4 read-only code rejects write");
    acc(32'h5001_0000, 0, 0, 0, 2'd3, "R1 above 64KB region unmatched");
    acc(32'h6000_001C, 0, 0, 0, 2'd0, "R1 minimum 32-byte region");
    acc(32'h6000_0020, 0, 0, 0, 2'd3, "R1 minimum size end");

    // permission sweep on region 4
    for (int code = 0; code < 8; code++) begin
      prog(4, 32'h5000_0000, 5'd15, 8'h00, 3'(code), 0);
      for (int pr = 0; pr < 2; pr++)
        for (int wr = 0; wr < 2; wr++)
          acc(32'h5000_0040, wr[0], 0, pr[0],
              perm_ok(code, pr[0], wr[0]) ? 2'd0 : 2'd1, "R4 permission code sweep");
    end

    // execute-never
    prog(4, 32'h5000_0000, 5'd15, 8'h00, 3'b011, 1);
    acc(32'h5000_0080, 0, 1, 1, 2'd2, "R5 fetch from execute-never");
    acc(32'h5000_0080, 0, 0, 1, 2'd0, "R5 data read in execute-never region");
    prog(4, 32'h5000_0000, 5'd15, 8'h00, 3'b011, 0);
    acc(32'h5000_0080, 0, 1, 0, 2'd0, "R5 fetch allowed without execute-never");

    // unprivileged config write ignored
    cfg_wr(3'd0, 32'd0, 0);
    cfg_chk(3'd0, 32'd3, "R9 unprivileged write ignored");
    acc(32'h7000_0000, 0, 0, 0, 2'd3, "R9 unit still enabled after unpriv write");

    // background off
    cfg_wr(3'd0, 32'd1, 1);
    acc(32'h7000_0000, 0, 0, 1, 2'd3, "R6 background off faults privileged");
    cfg_wr(3'd0, 32'd3, 1);

    // status and capture
    cfg_wr(3'd4, 32'h83, 1);
    cfg_chk(3'd4, 32'h0, "R12 status cleared");
    acc(32'h7000_0040, 0, 0, 0, 2'd3, "R11 first data fault");
    acc(32'h4000_1104, 1, 0, 0, 2'd1, "R11 second data fault");
    cfg_chk(3'd5, 32'h7000_0040, "R11 first address held");
    cfg_chk(3'd4, 32'h82, "R11 data status and address valid");
    cfg_wr(3'd4, 32'h82, 1);
    cfg_chk(3'd4, 32'h0, "R12 write back clears");
    prog(4, 32'h5000_0000, 5'd15, 8'h00, 3'b011, 1);
    acc(32'h5000_0000, 0, 1, 1, 2'd2, "R11 fetch fault");
    cfg_chk(3'd4, 32'h01, "R11 fetch status only");
    cfg_wr(3'd4, 32'h80, 1);
    cfg_chk(3'd4, 32'h01, "R12 zero bits leave status");
    cfg_wr(3'd4, 32'h01, 1);

    // disable unit
    cfg_wr(3'd0, 32'd0, 1);
    acc(32'h7000_0000, 1, 0, 0, 2'd0, "R7 disabled unmatched write");
    acc(32'h5000_0000, 0, 1, 0, 2'd0, "R7 disabled fetch from execute-never");
    cfg_chk(3'd4, 32'h0, "R7 status unchanged when disabled");

    repeat (3) @(negedge clk);
    chk("R8 all results seen", 32'(exp_q.size()), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule